// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt state of one processor thread for two privilege rings: an OS ring and a hypervisor physical ring. Each ring holds four byte registers: a pending-priority bitmap, the most favoured pending priority, the current processor priority, and a notification status byte. A priority is a value from 0 to 7, and a lower value is more favoured. The context also holds a 32-bit pool-ring context word and a one-byte hypervisor context word.

Software reaches the block through a byte-addressed register port. The port carries plain loads and stores plus special reads that have side effects: acknowledge a ring, and pull the pool context. A ring signals an exception when its most favoured pending priority is more favoured than its current priority. The block drives one registered interrupt line, which is the OR of the exception indications of both rings.

Address map (12-bit byte offsets). The OS ring base is 0x010 and the hypervisor ring base is 0x030. Within a ring, status is at +0, current priority at +1, pending bitmap at +2 and pending priority at +3 (read only). The pool word is at 0x028 and takes 4-byte accesses. The hypervisor word is at 0x038 and takes 1-byte accesses. Acknowledge of the OS ring is at 0x800, acknowledge of the hypervisor ring is at 0x830, and pool pull is at 0x838. Access size is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.

Top module: `tctx_ctx`

## Requirements
- R1: After reset each ring's current priority and status byte are 0, its pending bitmap equals its reset parameter (OS default 0x04, hypervisor default 0x00), its pending priority is derived from that bitmap (OS reads 5, hypervisor reads 0xFF), and irq_o is low; reset is asynchronous.
- R2: Bitmap bit (7-p) marks priority p pending. The pending priority (1-byte read at ring base +3) is the lowest pending p, or 0xFF when the bitmap is empty. It follows every bitmap change, including a 1-byte store at ring base +2.
- R3: When the OS pending priority is numerically below the OS current priority, status bit 7 of the OS ring is set.
- R4: When the hypervisor pending priority is below its current priority, status bits [7:6] of the hypervisor ring take code 01 (physical); codes 10 and 11 are never produced.
- R5: A 1-byte store at hypervisor base +1 loads the current priority from data bits [7:0] and re-evaluates notification. Any resulting irq_o change appears one cycle after the access.
- R6: A 2-byte read at 0x830 while the hypervisor exception is signalled returns {status, current priority} as they were before the access. It then sets current priority to the pending priority, clears that priority's bitmap bit, recomputes the pending priority and clears status bits [7:6].
- R7: A 2-byte read at 0x800 performs the same acknowledge on the OS ring and clears OS status bit 7.
- R8: irq_o is the registered OR of both rings' exception indications. It stays high after one ring is acknowledged while the other still signals, and falls once neither signals.
- R9: A 4-byte or 8-byte read at 0x838 returns bits [30:0] of the pool word, zero-extended. The same access clears those bits and keeps bit 31.
- R10: A 1-byte store at 0x038 keeps data bits [7:0], and a 1-byte read there returns them.
- R11: A store to an unmapped offset, or with a size not listed for its offset, changes no state. A read of such an access returns all ones. This includes an acknowledge or pull at the wrong size.
- R12: Read data appears on rdata_o with rvalid_o high exactly one cycle after the read request; rvalid_o is low in the cycle after a store or an idle cycle.
- R13: An acknowledge read while the ring signals no exception returns {status, current priority} and changes no ring state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| wdata_i | input | DATA_W | Store data, right aligned |
| rvalid_o | output | 1 | Load data valid |
| rdata_o | output | DATA_W | Load data, right aligned |
| irq_o | output | 1 | Thread interrupt line |

## Verification
Every result is due one clock edge after the access that causes it. This covers load data with rvalid_o, ring register updates and the irq_o edge, since irq_o is computed from the next-state status bytes and not from the registered ones. The bench drives each access on a falling edge. It samples rdata_o, rvalid_o and irq_o on the next falling edge, which is half a cycle after the single register stage. A state change is then confirmed by a following load. The reset check samples irq_o while reset is still asserted, because the reset is asynchronous.

// File: rtl/tctx_pkg.sv
package tctx_pkg;

  typedef enum logic [1:0] {SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2, SZ_8 = 2'd3} acc_size_e;

  localparam logic [7:0] PRIO_NONE = 8'hFF;

  // ring layout
  localparam int unsigned OS_BASE   = 'h010;
  localparam int unsigned POOL_BASE = 'h020;
  localparam int unsigned HV_BASE   = 'h030;
  localparam int unsigned B_NSR     = 0;
  localparam int unsigned B_CPPR    = 1;
  localparam int unsigned B_IPB     = 2;
  localparam int unsigned B_PIPR    = 3;
  localparam int unsigned B_WORD    = 8;

  // side-effect locations
  localparam int unsigned SPC_ACK_OS = 'h800;
  localparam int unsigned SPC_ACK_HV = 'h830;
  localparam int unsigned SPC_PULL   = 'h838;

  // exception encodings in the status byte
  localparam logic [7:0] OS_EXC_MASK = 8'h80;
  localparam logic [7:0] OS_EXC_CODE = 8'h80;
  localparam logic [7:0] HV_EXC_MASK = 8'hC0;
  localparam logic [7:0] HV_EXC_CODE = 8'h40;  // [7:6] = 01, physical

  function automatic logic [7:0] lead_prio(input logic [7:0] ipb);
    logic [7:0] p;
    p = PRIO_NONE;
    for (int i = 7; i >= 0; i--) begin
      if (ipb[7-i]) p = 8'(i);
    end
    return p;
  endfunction

endpackage

// File: rtl/tctx_ring.sv
module tctx_ring
  import tctx_pkg::*;
#(
  parameter bit         IS_HV   = 1'b0,
  parameter logic [7:0] IPB_RST = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ipb_we_i,
  input  logic       cppr_we_i,
  input  logic       ack_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] nsr_o,
  output logic [7:0] cppr_o,
  output logic [7:0] ipb_o,
  output logic [7:0] pipr_o,
  output logic       exc_d_o
);

  localparam logic [7:0] PIPR_RST = lead_prio(IPB_RST);

  logic [7:0] exc_mask, exc_code;
  logic [7:0] nsr_q, cppr_q, ipb_q, pipr_q;
  logic [7:0] nsr_d, cppr_d, ipb_d, pipr_d;
  logic       exc_q, accept;

  if (IS_HV) begin : g_hv
    assign exc_mask = HV_EXC_MASK;
    assign exc_code = HV_EXC_CODE;
  end else begin : g_os
    assign exc_mask = OS_EXC_MASK;
    assign exc_code = OS_EXC_CODE;
  end

  assign exc_q  = (nsr_q & exc_mask) == exc_code;
  assign accept = ack_i & exc_q;

  always_comb begin
    ipb_d  = ipb_q;
    cppr_d = cppr_q;
    nsr_d  = nsr_q;
    if (ipb_we_i)  ipb_d  = wbyte_i;
    if (cppr_we_i) cppr_d = wbyte_i;
    if (accept) begin
      cppr_d = pipr_q;
      if (pipr_q != PRIO_NONE) ipb_d = ipb_q & ~(8'h80 >> pipr_q[2:0]);
      nsr_d = nsr_q & ~exc_mask;
    end
    pipr_d = lead_prio(ipb_d);
    // notification evaluated on next-state values
    if (pipr_d < cppr_d) nsr_d = (nsr_d & ~exc_mask) | exc_code;
    exc_d_o = (nsr_d & exc_mask) == exc_code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipb_q  <= IPB_RST;
      pipr_q <= PIPR_RST;
      cppr_q <= 8'h00;
      nsr_q  <= 8'h00;
    end else begin
      ipb_q  <= ipb_d;
      pipr_q <= pipr_d;
      cppr_q <= cppr_d;
      nsr_q  <= nsr_d;
    end
  end

  assign nsr_o  = nsr_q;
  assign cppr_o = cppr_q;
  assign ipb_o  = ipb_q;
  assign pipr_o = pipr_q;

endmodule

// File: rtl/tctx_word.sv
module tctx_word #(
  parameter int unsigned     W        = 8,
  parameter logic [W-1:0]    CLR_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pull_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (we_i)   q <= wdata_i;
    else if (pull_i) q <= q & ~CLR_MASK;
  end

  assign q_o = q;

endmodule

// File: rtl/tctx_ctx.sv
module tctx_ctx
  import tctx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned POOL_W     = 32,
  parameter logic [7:0]  OS_IPB_RST = 8'h04,
  parameter logic [7:0]  HV_IPB_RST = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam logic [POOL_W-1:0] POOL_CAM = {1'b0, {(POOL_W-1){1'b1}}};

  logic rd, wr, sz1, sz2, sz4, sz8;
  logic os_ipb_we, os_cppr_we, hv_ipb_we, hv_cppr_we, hv_word_we, pool_we;
  logic ack_os, ack_hv, pull_pool;
  logic [7:0] os_nsr, os_cppr, os_ipb, os_pipr;
  logic [7:0] hv_nsr, hv_cppr, hv_ipb, hv_pipr;
  logic [7:0] hv_word;
  logic [POOL_W-1:0] pool_w2;
  logic os_exc_d, hv_exc_d;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic rvalid_q, irq_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:POOL_W];

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  assign rd  = req_i & ~we_i;
  assign wr  = req_i & we_i;
  assign sz1 = size_i == SZ_1;
  assign sz2 = size_i == SZ_2;
  assign sz4 = size_i == SZ_4;
  assign sz8 = size_i == SZ_8;

  assign os_cppr_we = wr & sz1 & at(addr_i, OS_BASE + B_CPPR);
  assign os_ipb_we  = wr & sz1 & at(addr_i, OS_BASE + B_IPB);
  assign hv_cppr_we = wr & sz1 & at(addr_i, HV_BASE + B_CPPR);
  assign hv_ipb_we  = wr & sz1 & at(addr_i, HV_BASE + B_IPB);
  assign hv_word_we = wr & sz1 & at(addr_i, HV_BASE + B_WORD);
  assign pool_we    = wr & sz4 & at(addr_i, POOL_BASE + B_WORD);
  assign ack_os     = rd & sz2 & at(addr_i, SPC_ACK_OS);
  assign ack_hv     = rd & sz2 & at(addr_i, SPC_ACK_HV);
  assign pull_pool  = rd & (sz4 | sz8) & at(addr_i, SPC_PULL);

  tctx_ring #(.IS_HV(1'b0), .IPB_RST(OS_IPB_RST)) u_os_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ipb_we_i  (os_ipb_we),
    .cppr_we_i (os_cppr_we),
    .ack_i     (ack_os),
    .wbyte_i   (wdata_i[7:0]),
    .nsr_o     (os_nsr),
    .cppr_o    (os_cppr),
    .ipb_o     (os_ipb),
    .pipr_o    (os_pipr),
    .exc_d_o   (os_exc_d)
  );

  tctx_ring #(.IS_HV(1'b1), .IPB_RST(HV_IPB_RST)) u_hv_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ipb_we_i  (hv_ipb_we),
    .cppr_we_i (hv_cppr_we),
    .ack_i     (ack_hv),
    .wbyte_i   (wdata_i[7:0]),
    .nsr_o     (hv_nsr),
    .cppr_o    (hv_cppr),
    .ipb_o     (hv_ipb),
    .pipr_o    (hv_pipr),
    .exc_d_o   (hv_exc_d)
  );

  tctx_word #(.W(POOL_W), .CLR_MASK(POOL_CAM)) u_pool_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pool_we),
    .wdata_i (wdata_i[POOL_W-1:0]),
    .pull_i  (pull_pool),
    .q_o     (pool_w2)
  );

  tctx_word #(.W(8), .CLR_MASK(8'h00)) u_hv_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hv_word_we),
    .wdata_i (wdata_i[7:0]),
    .pull_i  (1'b0),
    .q_o     (hv_word)
  );

  // load mux on pre-access state
  always_comb begin
    rdata_d = '1;
    if (sz1) begin
      if      (at(addr_i, OS_BASE + B_NSR))  rdata_d = DATA_W'(os_nsr);
      else if (at(addr_i, OS_BASE + B_CPPR)) rdata_d = DATA_W'(os_cppr);
      else if (at(addr_i, OS_BASE + B_IPB))  rdata_d = DATA_W'(os_ipb);
      else if (at(addr_i, OS_BASE + B_PIPR)) rdata_d = DATA_W'(os_pipr);
      else if (at(addr_i, HV_BASE + B_NSR))  rdata_d = DATA_W'(hv_nsr);
      else if (at(addr_i, HV_BASE + B_CPPR)) rdata_d = DATA_W'(hv_cppr);
      else if (at(addr_i, HV_BASE + B_IPB))  rdata_d = DATA_W'(hv_ipb);
      else if (at(addr_i, HV_BASE + B_PIPR)) rdata_d = DATA_W'(hv_pipr);
      else if (at(addr_i, HV_BASE + B_WORD)) rdata_d = DATA_W'(hv_word);
    end else if (ack_os) begin
      rdata_d = DATA_W'({os_nsr, os_cppr});
    end else if (ack_hv) begin
      rdata_d = DATA_W'({hv_nsr, hv_cppr});
    end else if (pull_pool) begin
      rdata_d = DATA_W'(pool_w2 & POOL_CAM);
    end else if (sz4 && at(addr_i, POOL_BASE + B_WORD)) begin
      rdata_d = DATA_W'(pool_w2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
      irq_q    <= os_exc_d | hv_exc_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/tctx_ctx_chk.sv
module tctx_ctx_chk
  import tctx_pkg::*;
#(
  parameter int unsigned POOL_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              rvalid_o,
  input logic              irq_o,
  input logic [7:0]        os_nsr,
  input logic [7:0]        os_cppr,
  input logic [7:0]        os_ipb,
  input logic [7:0]        os_pipr,
  input logic [7:0]        hv_nsr,
  input logic [7:0]        hv_cppr,
  input logic [7:0]        hv_ipb,
  input logic [7:0]        hv_pipr,
  input logic              ack_os,
  input logic              ack_hv,
  input logic              pull_pool,
  input logic [POOL_W-1:0] pool_w2
);

  p_pipr_tracks_ipb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_pipr == lead_prio(os_ipb) && hv_pipr == lead_prio(hv_ipb));

  p_os_notify_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_pipr < os_cppr) && !ack_os |=> os_nsr[7]);

  p_hv_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_nsr[7:6] != 2'b10 && hv_nsr[7:6] != 2'b11);

  p_ack_hv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hv && hv_nsr[7:6] == 2'b01 |=> hv_cppr == $past(hv_pipr) && hv_nsr[7:6] == 2'b00);

  p_ack_os_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_os && os_nsr[7] |=> os_cppr == $past(os_pipr) && !os_nsr[7]);

  p_irq_or_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (os_nsr[7] | (hv_nsr[7:6] == 2'b01)));

  p_pull_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_pool |=> pool_w2[POOL_W-2:0] == '0 && pool_w2[POOL_W-1] == $past(pool_w2[POOL_W-1]));

  p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);

  p_rvalid_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_ack_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hv && hv_nsr[7:6] == 2'b00 |=> hv_cppr == $past(hv_cppr) && hv_ipb == $past(hv_ipb));

endmodule

bind tctx_ctx tctx_ctx_chk #(.POOL_W(POOL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .rvalid_o  (rvalid_o),
  .irq_o     (irq_o),
  .os_nsr    (os_nsr),
  .os_cppr   (os_cppr),
  .os_ipb    (os_ipb),
  .os_pipr   (os_pipr),
  .hv_nsr    (hv_nsr),
  .hv_cppr   (hv_cppr),
  .hv_ipb    (hv_ipb),
  .hv_pipr   (hv_pipr),
  .ack_os    (ack_os),
  .ack_hv    (ack_hv),
  .pull_pool (pull_pool),
  .pool_w2   (pool_w2)
);

// File: tb/tctx_ctx_bench.sv
`timescale 1ns/1ps
module tctx_ctx_bench;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam logic [63:0] ONES = '1;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h013, 2'd0, 64'h0, 64'h05, 1'b0, 4'd1},          // R1 OS pipr from reset ipb
    '{1'b0, 12'h011, 2'd0, 64'h0, 64'h00, 1'b0, 4'd1},          // R1
    '{1'b0, 12'h033, 2'd0, 64'h0, 64'hFF, 1'b0, 4'd1},          // R1
    '{1'b0, 12'h010, 2'd0, 64'h0, 64'h00, 1'b0, 4'd1},          // R1
    '{1'b1, 12'h011, 2'd0, 64'hFF, 64'h0, 1'b1, 4'd3},          // R3 OS cppr FF
    '{1'b0, 12'h010, 2'd0, 64'h0, 64'h80, 1'b1, 4'd3},          // R3
    '{1'b0, 12'h800, 2'd1, 64'h0, 64'h80FF, 1'b0, 4'd7},        // R7 ack OS
    '{1'b0, 12'h011, 2'd0, 64'h0, 64'h05, 1'b0, 4'd7},          // R7
    '{1'b0, 12'h012, 2'd0, 64'h0, 64'h00, 1'b0, 4'd7},          // R7
    '{1'b0, 12'h013, 2'd0, 64'h0, 64'hFF, 1'b0, 4'd2},          // R2 empty
    '{1'b1, 12'h032, 2'd0, 64'h21, 64'h0, 1'b0, 4'd2},          // R2 prio 2 and 7
    '{1'b0, 12'h033, 2'd0, 64'h0, 64'h02, 1'b0, 4'd2},          // R2
    '{1'b1, 12'h031, 2'd0, 64'h03, 64'h0, 1'b1, 4'd5},          // R5 HV cppr 3
    '{1'b0, 12'h030, 2'd0, 64'h0, 64'h40, 1'b1, 4'd4},          // R4 code 01
    '{1'b0, 12'h830, 2'd1, 64'h0, 64'h4003, 1'b0, 4'd6},        // R6 ack HV
    '{1'b0, 12'h031, 2'd0, 64'h0, 64'h02, 1'b0, 4'd6},          // R6
    '{1'b0, 12'h033, 2'd0, 64'h0, 64'h07, 1'b0, 4'd6},          // R6
    '{1'b0, 12'h830, 2'd1, 64'h0, 64'h0002, 1'b0, 4'd13},       // R13 idle ack
    '{1'b0, 12'h032, 2'd0, 64'h0, 64'h01, 1'b0, 4'd13},         // R13
    '{1'b1, 12'h031, 2'd0, 64'hFF, 64'h0, 1'b1, 4'd5},          // R5
    '{1'b1, 12'h012, 2'd0, 64'h80, 64'h0, 1'b1, 4'd8},          // R8 both rings
    '{1'b0, 12'h830, 2'd1, 64'h0, 64'h40FF, 1'b1, 4'd8},        // R8 OS still up
    '{1'b0, 12'h800, 2'd1, 64'h0, 64'h8005, 1'b0, 4'd8},        // R8 falls
    '{1'b1, 12'h028, 2'd2, 64'h8000_1234, 64'h0, 1'b0, 4'd9},   // R9
    '{1'b0, 12'h028, 2'd2, 64'h0, 64'h8000_1234, 1'b0, 4'd9},   // R9
    '{1'b0, 12'h838, 2'd3, 64'h0, 64'h0000_1234, 1'b0, 4'd9},   // R9 pull 8B
    '{1'b0, 12'h028, 2'd2, 64'h0, 64'h8000_0000, 1'b0, 4'd9},   // R9
    '{1'b1, 12'h028, 2'd2, 64'hAB, 64'h0, 1'b0, 4'd9},          // R9
    '{1'b0, 12'h838, 2'd2, 64'h0, 64'hAB, 1'b0, 4'd9},          // R9 pull 4B
    '{1'b0, 12'h028, 2'd2, 64'h0, 64'h0, 1'b0, 4'd9},           // R9
    '{1'b1, 12'h038, 2'd0, 64'h1A5, 64'h0, 1'b0, 4'd10},        // R10
    '{1'b0, 12'h038, 2'd0, 64'h0, 64'hA5, 1'b0, 4'd10},         // R10
    '{1'b1, 12'h3F0, 2'd0, 64'h55, 64'h0, 1'b0, 4'd11},         // R11 unmapped
    '{1'b0, 12'h3F0, 2'd0, 64'h0, ONES, 1'b0, 4'd11},           // R11
    '{1'b1, 12'h011, 2'd1, 64'h77, 64'h0, 1'b0, 4'd11},         // R11 wrong size
    '{1'b0, 12'h011, 2'd0, 64'h0, 64'h00, 1'b0, 4'd11},         // R11
    '{1'b0, 12'h838, 2'd0, 64'h0, ONES, 1'b0, 4'd11},           // R11 pull size
    '{1'b0, 12'h800, 2'd0, 64'h0, ONES, 1'b0, 4'd11}            // R11 ack size
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] wdata_i = '0;
  logic        rvalid_o, irq_o;
  logic [63:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tctx_ctx u_tctx_ctx (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .rvalid_o, .rdata_o, .irq_o
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input vec_t v);
    req_i = 1'b1; we_i = v.we; addr_i = v.addr; size_i = v.size; wdata_i = v.wdata;
    @(negedge clk_i);
    req_i = 1'b0;
    check($sformatf("R%0d irq", v.req), 64'(irq_o), 64'(v.irq));
    check("R12 rvalid", 64'(rvalid_o), 64'(!v.we));
    if (!v.we) check($sformatf("R%0d rdata @%h", v.req, v.addr), rdata_o, v.exp);
  endtask

  task automatic op(input logic w, input logic [11:0] a, input logic [1:0] s,
                    input logic [63:0] d, input logic [63:0] e, input logic q, input logic [3:0] r);
    do_op('{w, a, s, d, e, q, r});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 irq in reset", 64'(irq_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) do_op(VEC[i]);

    @(negedge clk_i);
    check("R12 rvalid idle", 64'(rvalid_o), 64'h0);

    // R1 reset restores ring state mid-run
    op(1'b1, 12'h012, 2'd0, 64'h02, 64'h0, 1'b0, 4'd1);
    op(1'b1, 12'h011, 2'd0, 64'hFF, 64'h0, 1'b1, 4'd1);
    rst_ni = 1'b0;
    #1;
    check("R1 async irq", 64'(irq_o), 64'h0);
    check("R1 async rvalid", 64'(rvalid_o), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    op(1'b0, 12'h013, 2'd0, 64'h0, 64'h05, 1'b0, 4'd1);
    op(1'b0, 12'h012, 2'd0, 64'h0, 64'h04, 1'b0, 4'd1);
    op(1'b0, 12'h011, 2'd0, 64'h0, 64'h00, 1'b0, 4'd1);
    op(1'b0, 12'h038, 2'd0, 64'h0, 64'h00, 1'b0, 4'd10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule